// File: doc/BRIEF.md
# SPI NOR Command Sequencer

This block is a register-driven engine that runs single transactions against one SPI NOR flash device. Software fills a six-byte transmit bank and a bit count, sets a 24-bit program address and a write byte, and then writes a command byte. The engine frames the transaction with chip select and shifts bits out in SPI mode 0, most significant bit first. It samples the device's reply where a reply is expected. When the transaction and the following chip-select idle gap have both finished, it clears the command bits.

Three commands exist. A generic transfer sends the top N bits of the transmit bank, with the bank's highest byte sent first. A status read sends the status opcode and latches the byte that comes back. A byte program sends the program opcode, the three address bytes and the write byte, and it can advance the program address by one afterwards. Software tracks progress by polling the command register until it reads zero, or by polling the separate busy register. The flash's write-in-progress flag is bit 0 of the latched status byte. The engine does not wait on that flag; software polls it.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, the command register (address 0), the busy register (address 13), the status register (address 12) and the program address (addresses 8, 9 and 10) all read zero. `spi_cs_n` is high and `spi_sck` is low.
- R2: Command bit 0 (generic transfer) produces one chip-select-low frame with exactly N rising SCK edges, where N is the count register (address 1). The MOSI bits are the top N bits of the 48-bit value {bank5..bank0}, sent MSB first. Bank byte i sits at address 2+i.
- R3: A count above 48 sends 48 bits. A count of 0 produces no frame, and the command bits still clear.
- R4: While an operation runs, the command register reads back the accepted command bit and address 13 bit 0 reads 1. Both return to 0 only after chip select has returned high.
- R5: Command bit 7 (address advance) never reads back as 1 from address 0.
- R6: Command bit 1 (status read) sends the opcode parameter RDSR_OP followed by 8 further clocks. The 8 bits sampled on MISO during those clocks, MSB first, become readable at address 12.
- R7: Command bit 2 (byte program) sends a 40-bit frame made of PP_OP, then address bits 23:16 (address 10), then 15:8 (address 9), then 7:0 (address 8), then the write byte (address 11).
- R8: A byte program issued with bit 7 set leaves the program address one higher, modulo 2^24, with the carry passing across all three bytes. Without bit 7, or with any other command, the address is unchanged.
- R9: While busy, every register write is ignored, including a new command.
- R10: When several command bits are written together, the generic transfer takes priority over the status read, and the status read takes priority over the byte program. A command write with none of bits 2:0 set starts nothing.
- R11: SCK is low whenever chip select is high. Each SCK high phase and each low phase lasts CLK_DIV clocks. MOSI changes only while SCK is low.
- R12: Chip select stays high for more than 2*CLK_DIV clocks between any two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A wrong bit counter or bit selection shows up in the frame the flash model captures at the end of that same transaction. The symptom is an extra or missing SCK edge, or a bit shifted one position. A corrupted status capture or address increment is invisible on the pins, and appears only at the next register read after completion. A command bit that sticks or clears early shows up at the first poll, as an endless busy or as a new frame starting before the idle gap has run out. The bench sweeps every status byte value, every count from 0 to 48 plus an over-range count, and address carries at each byte boundary, including the wrap from the top address.

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int CLK_DIV = 2,
  parameter logic [7:0] RDSR_OP = 8'h05,
  parameter logic [7:0] PP_OP = 8'h02
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_cs_n,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int DIVW = $clog2(2 * CLK_DIV) + 1;
  localparam logic [DIVW-1:0] HALF_END = DIVW'(CLK_DIV - 1);
  localparam logic [DIVW-1:0] GAP_END = DIVW'(2 * CLK_DIV - 1);
  localparam logic [3:0] A_CMD = 4'd0, A_CNT = 4'd1, A_BANK = 4'd2, A_AD0 = 4'd8,
                         A_AD1 = 4'd9, A_AD2 = 4'd10, A_WD = 4'd11, A_STS = 4'd12, A_BSY = 4'd13;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} state_t;

  state_t          state;
  logic [7:0]      bank [6];
  logic [7:0]      cnt, wbyte, status, rx;
  logic [23:0]     prog_addr;
  logic [2:0]      cmd_bits, sel;
  logic            adv;
  logic [47:0]     shreg, ld_sh;
  logic [5:0]      nbits, bitcnt, ld_n;
  logic [DIVW-1:0] div;
  logic            sck_q, cs_q;

  wire busy  = state != S_IDLE;
  wire wr_ok = reg_wr && !busy;
  wire start = wr_ok && reg_addr == A_CMD && |reg_wdata[2:0];

  assign spi_sck  = sck_q;
  assign spi_cs_n = cs_q;
  assign spi_mosi = !cs_q && shreg[47];

  always_comb begin
    if (reg_wdata[0]) begin
      sel   = 3'b001;
      ld_sh = {bank[5], bank[4], bank[3], bank[2], bank[1], bank[0]};
      ld_n  = (cnt > 8'd48) ? 6'd48 : cnt[5:0];
    end else if (reg_wdata[1]) begin
      sel   = 3'b010;
      ld_sh = {RDSR_OP, 40'h0};
      ld_n  = 6'd16;
    end else begin
      sel   = 3'b100;
      ld_sh = {PP_OP, prog_addr, wbyte, 8'h00};
      ld_n  = 6'd40;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      A_CMD: reg_rdata = {5'b0, cmd_bits};
      A_CNT: reg_rdata = cnt;
      A_AD0: reg_rdata = prog_addr[7:0];
      A_AD1: reg_rdata = prog_addr[15:8];
      A_AD2: reg_rdata = prog_addr[23:16];
      A_WD:  reg_rdata = wbyte;
      A_STS: reg_rdata = status;
      A_BSY: reg_rdata = {7'b0, busy};
      default: if (reg_addr >= A_BANK && reg_addr < A_AD0) reg_rdata = bank[3'(reg_addr - A_BANK)];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      for (int i = 0; i < 6; i++) bank[i] <= 8'h00;
      cnt <= 8'h00; wbyte <= 8'h00; status <= 8'h00; rx <= 8'h00;
      prog_addr <= 24'h0; cmd_bits <= 3'b0; adv <= 1'b0;
      shreg <= 48'h0; nbits <= 6'd0; bitcnt <= 6'd0; div <= '0;
      sck_q <= 1'b0; cs_q <= 1'b1;
    end else begin
      if (wr_ok) begin
        case (reg_addr)
          A_CNT: cnt <= reg_wdata;
          A_AD0: prog_addr[7:0] <= reg_wdata;
          A_AD1: prog_addr[15:8] <= reg_wdata;
          A_AD2: prog_addr[23:16] <= reg_wdata;
          A_WD:  wbyte <= reg_wdata;
          default: ;
        endcase
        for (int i = 0; i < 6; i++)
          if (reg_addr == 4'(A_BANK + i)) bank[i] <= reg_wdata;
      end
      case (state)
        S_IDLE: if (start) begin
          cmd_bits <= sel;
          adv      <= reg_wdata[7];
          shreg    <= ld_sh;
          nbits    <= ld_n;
          bitcnt   <= 6'd0;
          div      <= '0;
          sck_q    <= 1'b0;
          cs_q     <= ld_n == 6'd0;
          state    <= (ld_n == 6'd0) ? S_GAP : S_XFER;
        end
        S_XFER: if (div == HALF_END) begin
          div <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx    <= {rx[6:0], spi_miso};
          end else begin
            sck_q <= 1'b0;
            shreg <= {shreg[46:0], 1'b0};
            if (bitcnt == nbits - 6'd1) begin
              cs_q  <= 1'b1;
              state <= S_GAP;
              if (cmd_bits[1]) status <= rx;
              if (cmd_bits[2] && adv) prog_addr <= prog_addr + 24'd1;
            end else bitcnt <= bitcnt + 6'd1;
          end
        end else div <= div + 1'b1;
        S_GAP: if (div == GAP_END) begin
          div      <= '0;
          state    <= S_IDLE;
          cmd_bits <= 3'b0;
          adv      <= 1'b0;
        end else div <= div + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module nor_cmd_seq_chk #(
  parameter int CLK_DIV = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic       mosi,
  input logic       busy,
  input logic [3:0] reg_addr,
  input logic [7:0] reg_rdata
);
  logic [15:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hi_cnt <= 16'hFFFF;
    else if (!cs_n) hi_cnt <= 16'd0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;

  // R11
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
  // R11
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (sck && $past(sck)) |-> $stable(mosi));
  // R12
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> hi_cnt >= 16'(2 * CLK_DIV));
  // R4
  busy_frame_chk: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> busy);
  // R4
  done_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> cs_n && $past(cs_n));
  // R5
  adv_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n) (reg_addr == 4'd0) |-> !reg_rdata[7]);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
  .busy(busy), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;
  localparam int CD = 2;
  localparam logic [7:0] RDSR = 8'h05, PP = 8'h02;

  logic clk = 0, rst_n = 0, reg_wr = 0, miso;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic cs_n, sck, mosi;
  int errors = 0, checks = 0;

  nor_cmd_seq #(.CLK_DIV(CD), .RDSR_OP(RDSR), .PP_OP(PP)) u_nor_cmd_seq (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso));

  always #5 clk = ~clk;

  logic [63:0] fbits;
  int fsck = 0, frames = 0, sck_bad = 0;
  logic [7:0] sts_val = 0;
  time t_rise = 0, t_csup = 0, min_gap = 1000000;
  logic seen_frame = 0;

  assign miso = (fsck >= 8 && fsck < 16) ? sts_val[4'(15 - fsck)] : 1'b0;

  always @(negedge cs_n) begin
    fbits = 0; fsck = 0;
    if (seen_frame && ($time - t_csup) < min_gap) min_gap = $time - t_csup;
  end
  always @(posedge cs_n) begin frames++; t_csup = $time; seen_frame = 1; end
  always @(posedge sck) if (!cs_n) begin fbits = {fbits[62:0], mosi}; fsck++; t_rise = $time; end
  always @(negedge sck) if ($time - t_rise != CD * 10) sck_bad++;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int k = 0; k < 5000; k++) begin rd(0, v); if (v == 0) return; end
    chk(0, "R4 command bits never cleared", 64'(v), 0);
  endtask

  task automatic run(input logic [7:0] c);
    wr(0, c); wait_idle();
  endtask

  task automatic set_addr(input logic [23:0] a);
    wr(8, a[7:0]); wr(9, a[15:8]); wr(10, a[23:16]);
  endtask

  task automatic get_addr(output logic [23:0] a);
    logic [7:0] b0, b1, b2;
    rd(8, b0); rd(9, b1); rd(10, b2); a = {b2, b1, b0};
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [47:0] data;
    logic [23:0] a;
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, v); chk(v == 0, "R1 cmd", v, 0);
    rd(13, v); chk(v == 0, "R1 busy", v, 0);
    rd(12, v); chk(v == 0, "R1 status", v, 0);
    get_addr(a); chk(a == 0, "R1 address", a, 0);
    chk(cs_n == 1 && sck == 0, "R1 pins", {cs_n, sck}, 2'b10);

    // R2 generic transfer, every count 1..48
    for (int n = 1; n <= 48; n++) begin
      for (int j = 0; j < 6; j++) wr(4'(2 + j), 8'(n * 37 + j * 91 + 5));
      data = 0;
      for (int j = 0; j < 6; j++) data[j*8 +: 8] = 8'(n * 37 + j * 91 + 5);
      wr(1, 8'(n));
      f0 = frames;
      run(8'h01);
      chk(frames == f0 + 1 && fsck == n, "R2 frame/edges", 64'(fsck), 64'(n));
      chk(fbits[47:0] == 48'(data >> (48 - n)), "R2 bits", fbits, 64'(data >> (48 - n)));
      chk(sck == 0 && cs_n == 1, "R11 idle after frame", sck, 0);
    end

    // R3 over-range count and zero count
    wr(1, 8'd60); run(8'h01);
    chk(fsck == 48 && fbits[47:0] == data, "R3 clamp to 48", 64'(fsck), 48);
    wr(1, 8'd0); f0 = frames; run(8'h01);
    chk(frames == f0, "R3 zero count no frame", 64'(frames - f0), 0);
    rd(0, v); chk(v == 0, "R3 zero count clears", v, 0);

    // R4/R5 busy visibility, address-advance bit hidden
    wr(1, 8'd32); wr(0, 8'h81);
    rd(0, v); chk(v == 8'h01, "R4/R5 cmd read while busy", v, 8'h01);
    rd(13, v); chk(v == 8'h01, "R4 busy flag", v, 1);
    // R9 writes while busy ignored
    wr(7, 8'hEE); wr(1, 8'd8); wr(0, 8'h02);
    wait_idle();
    rd(13, v); chk(v == 0, "R4 busy cleared", v, 0);
    rd(7, v); chk(v == 8'(48 * 37 + 5 * 91 + 5), "R9 bank write ignored", v, 8'(48 * 37 + 5 * 91 + 5));
    rd(1, v); chk(v == 8'd32, "R9 count write ignored", v, 32);
    chk(fsck == 32, "R9 no second command", 64'(fsck), 32);
    rd(12, v); chk(v == 0, "R9 status untouched", v, 0);

    // R6 status read, every status value
    for (int s = 0; s < 256; s++) begin
      sts_val = 8'(s);
      run(8'h02);
      rd(12, v);
      chk(v == 8'(s), "R6 status capture", v, s);
      chk(fsck == 16 && fbits[15:8] == RDSR, "R6 opcode frame", fbits[15:0], {RDSR, 8'h00});
    end

    // R7/R8 byte program with address advance and carries
    for (int t = 0; t < 5; t++) begin
      logic [23:0] st;
      st = (t == 0) ? 24'h0000FF : (t == 1) ? 24'h00FFFF : (t == 2) ? 24'hFFFFFF :
           (t == 3) ? 24'h123456 : 24'hABCDEF;
      set_addr(st); wr(11, 8'(t * 17 + 3));
      run(8'h84);
      chk(fsck == 40 && fbits[39:0] == {PP, st, 8'(t * 17 + 3)}, "R7 program frame",
          fbits[39:0], {PP, st, 8'(t * 17 + 3)});
      get_addr(a); chk(a == st + 24'd1, "R8 advance with carry", a, st + 24'd1);
      run(8'h04);
      chk(fbits[39:0] == {PP, st + 24'd1, 8'(t * 17 + 3)}, "R7 second frame",
          fbits[39:0], {PP, st + 24'd1, 8'(t * 17 + 3)});
      get_addr(a); chk(a == st + 24'd1, "R8 no advance without bit7", a, st + 24'd1);
    end
    set_addr(24'h000010); wr(1, 8'd8); run(8'h81); run(8'h82);
    get_addr(a); chk(a == 24'h000010, "R8 other commands keep address", a, 24'h10);

    // R10 priority
    wr(1, 8'd8); wr(7, 8'hC3); run(8'h07);
    chk(fsck == 8 && fbits[7:0] == 8'hC3, "R10 transfer wins", fbits[7:0], 8'hC3);
    run(8'h06);
    chk(fsck == 16 && fbits[15:8] == RDSR, "R10 status over program", 64'(fsck), 16);
    f0 = frames; wr(0, 8'h80); rd(13, v);
    chk(v == 0 && frames == f0, "R10 no command bits", v, 0);

    // R11/R12 timing
    chk(sck_bad == 0, "R11 SCK half periods", 64'(sck_bad), 0);
    chk(min_gap > CD * 2 * 10, "R12 CS gap", 64'(min_gap), 64'(CD * 2 * 10 + 10));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule